// File: doc/BRIEF.md
# Tiled Gram-Matrix Multiply Engine

The engine forms the symmetric product G = A·Aᵀ for an integer matrix A of ROWS rows by COLS columns that sits in external memory. The work is cut into square TILE×TILE blocks. Because the result is symmetric, only result blocks on or above the block diagonal are produced. For each such block (i, j) the engine steps k along the shared column dimension. At each step it loads two blocks from memory into on-chip storage: block (i, k) of A, and block (j, k) of A, which is written in transposed form so that it serves as block (k, j) of Aᵀ. It multiplies the pair into an on-chip partial-sum block.

Storage has two banks for each operand. The fetcher fills one bank while the datapath multiplies out of the other, and the banks swap when a partial product ends. A bank that is in use is never refilled. The datapath produces one result element per cycle from TILE parallel products. In the last partial step the finished element goes straight to the write port. A one-cycle done pulse follows the final write. Cycles that the datapath spends waiting for a late operand pair are counted on `stall_count`.

TILE must be a power of two of at least 2, and ROWS and COLS must be multiples of TILE. Words are 32-bit and all arithmetic wraps modulo 2^32.

The compute controller has five states. IDLE moves to PRIME on an accepted start. PRIME moves to MAC once the first bank is loaded. MAC stays in MAC when the next pair is ready at the end of a partial product. MAC goes to WAIT when the next pair is not ready, and to DONE after the final element. WAIT moves to MAC when its bank fills. DONE always returns to IDLE.

The fetcher has three states. HALT moves to HOLD on start. HOLD moves to READ once the target bank is empty. READ goes back to HOLD after the last row of a pair, or to HALT after the last pair.

Top module: `gram_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req`, `wr_en` and `stall_count` are all 0.
- R2: Every written word equals the sum over all columns k of A[r][k]·A[c][k], truncated to 32 bits. Here r = wr_addr / ROWS and c = wr_addr % ROWS.
- R3: Writes are made only for blocks with block row ≤ block column. Each element of those blocks is written exactly once, so a job makes TILES·(TILES+1)/2·TILE² writes in total.
- R4: Result blocks leave in row-major block order over the pairs i ≤ j. Inside a block, elements leave in row-major order, one per cycle, so wr_addr = r·ROWS + c.
- R5: Only A is read. Each read is one block row of TILE consecutive words at word address row·COLS + k·TILE, returned packed with word w in bits [32w+31:32w]. A request holds its address until `rd_valid`. For each pair the engine reads the TILE rows of block (i, k) and then the TILE rows of block (j, k), each in increasing row order.
- R6: A bank being multiplied is never refilled. Results stay correct when read responses arrive late.
- R7: When `rd_valid` answers every request in the cycle it is raised, and 2·TILE+1 ≤ TILE², `stall_count` is 0 at the end of a job.
- R8: `stall_count` counts the cycles the datapath waits for an operand pair after the first pair. It is cleared by an accepted start and is non-zero when responses are slow.
- R9: `busy` is 1 from the cycle after an accepted start until the done cycle. `done` is a single-cycle pulse in the cycle right after the final write.
- R10: A `start` pulse while `busy` is 1 is ignored. The job in progress keeps its read and write sequence.
- R11: The partial-sum block is reset by the first partial step of each result block, so no value carries over between blocks or between jobs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (taken only when idle) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse after the last write |
| rd_req | output | 1 | Block-row read request |
| rd_addr | output | ADDR_W | Word address of the first word of the row |
| rd_valid | input | 1 | Read data present this cycle |
| rd_data | input | TILE·32 | TILE packed words |
| wr_en | output | 1 | Result word valid |
| wr_addr | output | ADDR_W | Result index r·ROWS + c |
| wr_data | output | 32 | Result word |
| stall_count | output | STALL_W | Datapath wait cycles in the current or last job |

## Verification
The engine is run with small ramped entries, where a swapped operand or a misplaced transpose gives a visibly wrong sum. It is also run with hashed entries, where every element position is distinct, and with entries near 2^32, which tell correct modulo wrap apart from lost carries. Zero-latency memory separates a working prefetch overlap (no stalls) from serialised fetching. Slow memory forces the wait path and checks bank protection. Two jobs back to back, the first with large values, expose partial sums that survive between jobs. A start pulse in mid-job shows whether the controller restarts.

// File: rtl/gram_pkg.sv
package gram_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
    typedef enum logic [2:0] {C_IDLE, C_PRIME, C_MAC, C_WAIT, C_DONE} cstate_t;
    typedef enum logic [1:0] {F_HALT, F_HOLD, F_READ} fstate_t;
endpackage

// File: rtl/gram_step_iter.sv
// Walks (i, j, k) over upper-triangular block pairs, k innermost.
module gram_step_iter #(
    parameter int TILES  = 2,
    parameter int KSTEPS = 2,
    parameter int IW     = (TILES > 1) ? $clog2(TILES) : 1,
    parameter int KW     = (KSTEPS > 1) ? $clog2(KSTEPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    output logic [IW-1:0] ti,
    output logic [IW-1:0] tj,
    output logic [KW-1:0] tk,
    output logic          last_k,
    output logic          final_step
);
    localparam logic [IW-1:0] T_LAST = IW'(TILES - 1);
    localparam logic [KW-1:0] K_LAST = KW'(KSTEPS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ti <= '0;
            tj <= '0;
            tk <= '0;
        end else if (restart) begin
            ti <= '0;
            tj <= '0;
            tk <= '0;
        end else if (advance) begin
            if (!last_k) begin
                tk <= tk + 1'b1;
            end else begin
                tk <= '0;
                if (tj != T_LAST) begin
                    tj <= tj + 1'b1;
                end else begin
                    ti <= ti + 1'b1;
                    tj <= ti + 1'b1;
                end
            end
        end
    end

    always_comb begin
        last_k     = (tk == K_LAST);
        final_step = last_k && (ti == T_LAST) && (tj == T_LAST);
    end
endmodule

// File: rtl/gram_dot.sv
// TILE parallel products summed into one word.
module gram_dot
    import gram_pkg::*;
#(
    parameter int TILE = 4
) (
    input  logic [TILE*WORD_W-1:0] row_v,
    input  logic [TILE*WORD_W-1:0] col_v,
    output word_t                  dot
);
    word_t prod [TILE];

    for (genvar g = 0; g < TILE; g++) begin : g_mul
        assign prod[g] = row_v[g*WORD_W +: WORD_W] * col_v[g*WORD_W +: WORD_W];
    end

    always_comb begin
        dot = '0;
        for (int t = 0; t < TILE; t++) begin
            dot = dot + prod[t];
        end
    end
endmodule

// File: rtl/gram_fetch.sv
// Loads one operand pair per step into the bank that is not in use.
module gram_fetch
    import gram_pkg::*;
#(
    parameter int TILE   = 4,
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic [1:0]              bank_full,
    output logic                    rd_req,
    output logic [ADDR_W-1:0]       rd_addr,
    input  logic                    rd_valid,
    output logic                    fill_we,
    output logic                    fill_is_b,
    output logic [$clog2(TILE)-1:0] fill_row,
    output logic                    fill_bank,
    output logic                    fill_done
);
    localparam int TILES  = ROWS / TILE;
    localparam int KSTEPS = COLS / TILE;
    localparam int IW     = (TILES > 1) ? $clog2(TILES) : 1;
    localparam int KW     = (KSTEPS > 1) ? $clog2(KSTEPS) : 1;
    localparam int RW     = $clog2(TILE);
    localparam int CW     = RW + 1;
    localparam logic [CW-1:0]     LAST_C = CW'(2 * TILE - 1);
    localparam logic [ADDR_W-1:0] TILE_A = ADDR_W'(TILE);
    localparam logic [ADDR_W-1:0] COLS_A = ADDR_W'(COLS);

    fstate_t       fstate, fnext;
    logic [CW-1:0] cnt;
    logic          wbank;
    logic [IW-1:0] ti, tj, src;
    logic [KW-1:0] tk;
    logic          last_k, final_step;

    gram_step_iter #(.TILES(TILES), .KSTEPS(KSTEPS)) u_iter (
        .clk(clk), .rst_n(rst_n), .restart(go), .advance(fill_done),
        .ti(ti), .tj(tj), .tk(tk), .last_k(last_k), .final_step(final_step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fstate <= F_HALT;
            cnt    <= '0;
            wbank  <= 1'b0;
        end else begin
            fstate <= fnext;
            if (go) begin
                cnt   <= '0;
                wbank <= 1'b0;
            end else if (fill_we) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST_C) wbank <= ~wbank;
            end
        end
    end

    always_comb begin
        fnext = fstate;
        unique case (fstate)
            F_HALT:  fnext = go ? F_HOLD : F_HALT;
            F_HOLD:  fnext = bank_full[wbank] ? F_HOLD : F_READ;
            F_READ:  if (rd_valid && cnt == LAST_C) fnext = final_step ? F_HALT : F_HOLD;
            default: fnext = F_HALT;
        endcase
    end

    always_comb begin
        rd_req    = (fstate == F_READ);
        fill_we   = rd_req && rd_valid;
        fill_done = fill_we && (cnt == LAST_C);
        fill_row  = cnt[RW-1:0];
        fill_is_b = cnt[RW];
        fill_bank = wbank;
        src       = fill_is_b ? tj : ti;
        rd_addr   = (ADDR_W'(src) * TILE_A + ADDR_W'(fill_row)) * COLS_A
                  + ADDR_W'(tk) * TILE_A;
    end

    // R5: a pending request keeps its address until answered
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/gram_engine.sv
module gram_engine
    import gram_pkg::*;
#(
    parameter int TILE    = 4,
    parameter int ROWS    = 8,
    parameter int COLS    = 8,
    parameter int ADDR_W  = 16,
    parameter int STALL_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic                   rd_req,
    output logic [ADDR_W-1:0]      rd_addr,
    input  logic                   rd_valid,
    input  logic [TILE*WORD_W-1:0] rd_data,
    output logic                   wr_en,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [WORD_W-1:0]      wr_data,
    output logic [STALL_W-1:0]     stall_count
);
    localparam int TILES  = ROWS / TILE;
    localparam int KSTEPS = COLS / TILE;
    localparam int ELEMS  = TILE * TILE;
    localparam int EW     = $clog2(ELEMS);
    localparam int RW     = $clog2(TILE);
    localparam int IW     = (TILES > 1) ? $clog2(TILES) : 1;
    localparam int KW     = (KSTEPS > 1) ? $clog2(KSTEPS) : 1;
    localparam logic [RW-1:0]     R_LAST = RW'(TILE - 1);
    localparam logic [ADDR_W-1:0] TILE_A = ADDR_W'(TILE);
    localparam logic [ADDR_W-1:0] ROWS_A = ADDR_W'(ROWS);

    cstate_t cstate, cnext;
    logic    go;

    // operand banks and partial-sum block
    word_t a_buf [2][ELEMS];
    word_t b_buf [2][ELEMS];
    word_t acc   [ELEMS];
    logic [1:0] full;
    logic       rbank;

    logic [RW-1:0] er, ec;
    logic [EW-1:0] ent_idx;
    logic          mac_last, next_ready;
    logic [STALL_W-1:0] stall_q;

    logic                fill_we, fill_is_b, fill_bank, fill_done;
    logic [RW-1:0]       fill_row;
    logic [IW-1:0]       ti, tj;
    logic [KW-1:0]       tk;
    logic                last_k, final_step;
    logic [TILE*WORD_W-1:0] a_row, b_col;
    word_t               dot, acc_new;

    assign go = start && (cstate == C_IDLE);

    gram_fetch #(.TILE(TILE), .ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(go), .bank_full(full),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .fill_we(fill_we), .fill_is_b(fill_is_b), .fill_row(fill_row),
        .fill_bank(fill_bank), .fill_done(fill_done)
    );

    gram_step_iter #(.TILES(TILES), .KSTEPS(KSTEPS)) u_citer (
        .clk(clk), .rst_n(rst_n), .restart(go), .advance(mac_last),
        .ti(ti), .tj(tj), .tk(tk), .last_k(last_k), .final_step(final_step)
    );

    gram_dot #(.TILE(TILE)) u_dot (.row_v(a_row), .col_v(b_col), .dot(dot));

    // bank fill: A rows straight, second block written transposed
    always_ff @(posedge clk) begin
        if (fill_we) begin
            for (int w = 0; w < TILE; w++) begin
                if (!fill_is_b)
                    a_buf[fill_bank][EW'(int'(fill_row) * TILE + w)] <= rd_data[w*WORD_W +: WORD_W];
                else
                    b_buf[fill_bank][EW'(w * TILE + int'(fill_row))] <= rd_data[w*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        for (int t = 0; t < TILE; t++) begin
            a_row[t*WORD_W +: WORD_W] = a_buf[rbank][EW'(int'(er) * TILE + t)];
            b_col[t*WORD_W +: WORD_W] = b_buf[rbank][EW'(t * TILE + int'(ec))];
        end
        ent_idx    = EW'(int'(er) * TILE + int'(ec));
        acc_new    = ((tk == '0) ? '0 : acc[ent_idx]) + dot;
        mac_last   = (cstate == C_MAC) && (er == R_LAST) && (ec == R_LAST);
        next_ready = full[~rbank] || (fill_done && (fill_bank == ~rbank));
    end

    always_ff @(posedge clk) begin
        if (cstate == C_MAC) acc[ent_idx] <= acc_new;
    end

    // bank ownership flags: set by the fetcher, released by the datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= '0;
        end else if (go) begin
            full <= '0;
        end else begin
            if (mac_last)  full[rbank]     <= 1'b0;
            if (fill_done) full[fill_bank] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            er      <= '0;
            ec      <= '0;
            rbank   <= 1'b0;
            stall_q <= '0;
        end else if (go) begin
            er      <= '0;
            ec      <= '0;
            rbank   <= 1'b0;
            stall_q <= '0;
        end else begin
            if (cstate == C_MAC) begin
                ec <= ec + 1'b1;
                if (ec == R_LAST) er <= er + 1'b1;
                if (mac_last) rbank <= ~rbank;
            end
            if (cstate == C_WAIT) stall_q <= stall_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cstate <= C_IDLE;
        else        cstate <= cnext;
    end

    always_comb begin
        cnext = cstate;
        unique case (cstate)
            C_IDLE:  if (go) cnext = C_PRIME;
            C_PRIME: if (full[rbank]) cnext = C_MAC;
            C_MAC:   if (mac_last) begin
                         if (final_step)      cnext = C_DONE;
                         else if (next_ready) cnext = C_MAC;
                         else                 cnext = C_WAIT;
                     end
            C_WAIT:  if (full[rbank]) cnext = C_MAC;
            C_DONE:  cnext = C_IDLE;
            default: cnext = C_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = (cstate != C_IDLE);
        done        = (cstate == C_DONE);
        wr_en       = (cstate == C_MAC) && last_k;
        wr_addr     = (ADDR_W'(ti) * TILE_A + ADDR_W'(er)) * ROWS_A
                    + ADDR_W'(tj) * TILE_A + ADDR_W'(ec);
        wr_data     = acc_new;
        stall_count = stall_q;
    end

    // R6: the fetcher never writes the bank being multiplied
    p_no_live_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && cstate == C_MAC) |-> (fill_bank != rbank));

    // R3: writes stay in the upper block triangle
    p_upper_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((int'(wr_addr) / ROWS) / TILE <= (int'(wr_addr) % ROWS) / TILE));

    // R9: done lasts one cycle and follows a write
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    // R8: no stall counted while multiplying
    p_stall_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == C_MAC) |=> $stable(stall_count));
endmodule

// File: tb/gram_engine_tb_top.sv
`timescale 1ns/1ps
module gram_engine_tb_top;
    localparam int TILE = 4, ROWS = 8, COLS = 8, ADDR_W = 16, STALL_W = 16;
    localparam int TL = ROWS / TILE, KT = COLS / TILE, ELEMS = TILE * TILE;
    localparam int NT = TL * (TL + 1) / 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, rd_req, rd_valid = 1'b0, wr_en;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [TILE*32-1:0] rd_data = '0;
    logic [31:0] wr_data;
    logic [STALL_W-1:0] stall_count;

    logic [31:0] amem [ROWS*COLS];
    int errors = 0, checks = 0;
    int gap = 0, gcnt = 0, cyc = 0;
    int wr_count = 0, rd_count = 0, done_seen = 0, last_wr_cyc = -10;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gram_engine #(.TILE(TILE), .ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .STALL_W(STALL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stall_count(stall_count)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void tile_of(int tn, output int bi, output int bj);
        int n = 0;
        bi = 0; bj = 0;
        for (int i = 0; i < TL; i++)
            for (int j = i; j < TL; j++) begin
                if (n == tn) begin bi = i; bj = j; end
                n++;
            end
    endfunction

    function automatic logic [31:0] gold(int r, int c);
        logic [31:0] s = '0;
        for (int k = 0; k < COLS; k++) s = s + amem[r*COLS+k] * amem[c*COLS+k];
        return s;
    endfunction

    function automatic logic [31:0] pat(int mode, int r, int c);
        case (mode)
            0: return 32'(r + c + 1);
            1: return 32'((r * 37 + c * 101 + 7) * 32'd2654435761);
            default: return 32'hFFFF_FF00 + 32'(r * 3 + c);
        endcase
    endfunction

    // memory model: answers a request after gap idle cycles
    initial forever begin
        @(negedge clk);
        if (rd_req && gcnt >= gap) begin
            rd_valid = 1'b1;
            gcnt = 0;
            for (int w = 0; w < TILE; w++)
                rd_data[w*32 +: 32] = (int'(rd_addr) + w < ROWS*COLS) ? amem[int'(rd_addr) + w] : '0;
        end else begin
            rd_valid = 1'b0;
            if (rd_req) gcnt++;
        end
    end

    // output monitor
    initial forever begin
        @(negedge clk);
        #1;
        cyc++;
        if (wr_en) begin
            int tn, e, bi, bj, r, c;
            tn = wr_count / ELEMS;
            e  = wr_count % ELEMS;
            tile_of(tn, bi, bj);
            r = bi*TILE + e/TILE;
            c = bj*TILE + e%TILE;
            chk(int'(wr_addr) == r*ROWS + c, "R4 write order", wr_addr, r*ROWS + c);
            chk(wr_data == gold(r, c), "R2 result value", wr_data, gold(r, c));
            wr_count++;
            last_wr_cyc = cyc;
        end
        if (rd_req && rd_valid) begin
            int p, q, bi, bj, k, row, ea;
            p = rd_count / (2*TILE);
            q = rd_count % (2*TILE);
            tile_of(p / KT, bi, bj);
            k = p % KT;
            row = (q < TILE) ? bi*TILE + q : bj*TILE + q - TILE;
            ea = row*COLS + k*TILE;
            chk(int'(rd_addr) == ea, "R5 read address", rd_addr, ea);
            rd_count++;
        end
        if (done) begin
            done_seen++;
            chk(last_wr_cyc == cyc - 1, "R9 done after final write", last_wr_cyc, cyc - 1);
        end
    end

    task automatic load(int mode);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) amem[r*COLS+c] = pat(mode, r, c);
    endtask

    task automatic run_job(int mode, int g, bit poke, output int stalls);
        load(mode);
        gap = g; gcnt = 0;
        wr_count = 0; rd_count = 0; done_seen = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        #2;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            start = (poke && t == 20) ? 1'b1 : 1'b0;
            #2;
            if (done_seen != 0) break;
        end
        start = 1'b0;
        @(negedge clk); #2;
        chk(done_seen == 1, "R9 one done pulse", done_seen, 1);
        chk(busy == 1'b0, "R9 idle after done", busy, 0);
        chk(wr_count == NT*ELEMS, "R3 write count", wr_count, NT*ELEMS);
        chk(rd_count == NT*KT*2*TILE, "R5 read count", rd_count, NT*KT*2*TILE);
        stalls = int'(stall_count);
    endtask

    task automatic t_reset;
        #1;
        chk(busy == 0 && done == 0, "R1 busy/done at reset", {busy, done}, 0);
        chk(rd_req == 0 && wr_en == 0, "R1 ports at reset", {rd_req, wr_en}, 0);
        chk(stall_count == 0, "R1 stall_count at reset", stall_count, 0);
    endtask

    task automatic t_ramp_fast;
        int s;
        run_job(0, 0, 0, s);
        chk(s == 0, "R7 no stall with prompt memory", s, 0);
    endtask

    task automatic t_hash_fast;
        int s;
        run_job(1, 0, 0, s);
        chk(s == 0, "R7 no stall hashed data", s, 0);
    endtask

    task automatic t_slow_memory;
        int s;
        run_job(1, 3, 0, s);
        chk(s > 0, "R8 stall counted with slow memory (R6 values checked)", s, 1);
    endtask

    task automatic t_wrap_then_ramp;
        int s;
        run_job(2, 1, 0, s);   // R2 modulo wrap
        run_job(0, 0, 0, s);   // R11 nothing left from the previous job
        chk(s == 0, "R8 stall_count cleared by start (R11)", s, 0);
    endtask

    task automatic t_start_ignored;
        int s;
        run_job(1, 2, 1, s);   // R10: order checks catch a restart
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_ramp_fast();
        t_hash_fast();
        t_slow_memory();
        t_wrap_then_ramp();
        t_start_ignored();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule